// File: doc/BRIEF.md
# Early-Release Sync Word Inserter

This block sits on the 32-bit configuration data path of a programmable device after the main image has been streamed. Some devices need extra clocked data before they report that early user mode has been reached. On a start pulse the block keeps offering padding words of all ones, one at a time, until the device's early-user-mode status goes high or a cycle budget runs out. It also holds the clock-to-data ratio setting of the data path.

While it pads, the block parks the ratio at unity (code 0), so each padding word costs one data clock. Before that it saves the value software had written. On success it restores the saved value. It reports how many padding words the device accepted. A timeout leaves the ratio at unity and raises a sticky error flag.

Top module: `sync_pad_inserter`

## Requirements
- R1: Every word offered on `word_data` while `word_valid` is high equals 32'hFFFF_FFFF. A word stays offered until `word_ready` is seen high, unless the run times out.
- R2: A start with `early_user` low does three things. It saves the current ratio, sets `ratio` to the unity code 0 and raises `word_valid`. All three are visible in the cycle after the start edge.
- R3: A start with `early_user` already high offers no word. It raises `done` in the cycle after the start edge, reports a count of 0 and leaves `ratio` unchanged.
- R4: After each accepted word, `word_valid` stays low for exactly GAP_CYCLES cycles before the next word is offered. With `word_ready` held high, accepted words are therefore GAP_CYCLES+1 cycles apart.
- R5: `early_user` is sampled once at the end of each gap. If it is high, `done` rises GAP_CYCLES cycles after the edge that accepted the last word. In the same cycle the saved ratio is written back, and no further word is offered.
- R6: `extra_count` equals the number of edges on which `word_valid` and `word_ready` were both high during the run. This includes a word accepted on the edge where the run times out.
- R7: If `done` has not risen, `timeout` goes high exactly TIMEOUT_CYCLES cycles after the start edge. At the same time `word_valid` drops and `ratio` stays at 0.
- R8: `done` and `timeout` are never high together. Each one holds until the next start, which clears both flags and the count.
- R9: A ratio write while idle takes effect in the next cycle. A ratio write during a run has no effect on `ratio` or on the value restored at the end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to begin padding (ignored while busy) |
| early_user | input | 1 | Device reports early user mode |
| ratio_wr_en | input | 1 | Write strobe for the ratio setting |
| ratio_wr_data | input | RATIO_W | Value to write into the ratio setting |
| ratio | output | RATIO_W | Current clock-to-data ratio setting (0 = unity) |
| word_valid | output | 1 | A padding word is offered |
| word_data | output | DATA_W | Padding word |
| word_ready | input | 1 | Downstream accepts the offered word |
| done | output | 1 | Early user mode reached; sticky until next start |
| timeout | output | 1 | Budget expired first; sticky until next start |
| extra_count | output | CNT_W | Padding words accepted in the last run |

## Verification
Each result is due at a fixed number of edges after its cause. The ratio value, the first word and the early-success `done` are due one edge after the start. The return of `word_valid` and the success `done` are due GAP_CYCLES edges after an accepting edge. `timeout` is due TIMEOUT_CYCLES edges after the start edge. The bench drives inputs and samples outputs on falling edges. It counts falling edges from the edge that caused each result. It checks both the last cycle before a flag is due and the cycle it rises, so an early or late result is reported. The expected word count for a timed-out run with constant ready comes from a closed-form bench function, not from the design.

// File: rtl/sip_pkg.sv
// Shared types for the sync word inserter.
// Assumes: nothing beyond IEEE 1800-2017.
package sip_pkg;
    typedef enum logic [1:0] {
        SIP_IDLE = 2'd0,
        SIP_SEND = 2'd1,
        SIP_GAP  = 2'd2
    } sip_state_e;
endpackage

// File: rtl/sip_ratio_reg.sv
// Holds the clock-to-data ratio setting. On 'enter' it saves the live value
// and forces the unity code; on 'restore' it writes the saved value back.
// Assumes: enter and restore are never high in the same cycle.
module sip_ratio_reg #(
    parameter int RATIO_W   = 2,
    parameter int RATIO_ONE = 0,
    parameter int RATIO_RST = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [RATIO_W-1:0] wr_data,
    input  logic               busy,
    input  logic               enter,
    input  logic               restore,
    output logic [RATIO_W-1:0] ratio
);
    localparam logic [RATIO_W-1:0] ONE_CODE = RATIO_W'(RATIO_ONE);
    localparam logic [RATIO_W-1:0] RST_CODE = RATIO_W'(RATIO_RST);

    logic [RATIO_W-1:0] saved_q;

    // Live ratio: forced, restored, or written by software when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio   <= RST_CODE;
            saved_q <= RST_CODE;
        end else if (enter) begin
            saved_q <= ratio;
            ratio   <= ONE_CODE;
        end else if (restore) begin
            ratio   <= saved_q;
        end else if (wr_en && !busy) begin
            ratio   <= wr_data;
        end
    end
endmodule

// File: rtl/sip_gap_counter.sv
// Down-counter that paces padding words. 'load' starts a gap of GAP cycles;
// 'zero' is high in the last cycle of the gap.
// Assumes: GAP >= 1.
module sip_gap_counter #(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic zero
);
    localparam int GW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [GW-1:0] LOAD_VAL = GW'(GAP - 1);

    logic [GW-1:0] cnt_q;

    // Count down from GAP-1 to 0 and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= LOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sip_budget_timer.sv
// Counts cycles since the start edge while a run is active. 'expired' is
// high in the cycle whose closing edge is LIMIT edges after the start edge.
// Assumes: LIMIT >= 2; 'clear' is pulsed on the start edge.
module sip_budget_timer #(
    parameter int LIMIT = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] tick_q;

    // Elapsed-cycle counter that stops at its last value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tick_q <= '0;
        else if (clear)
            tick_q <= '0;
        else if (run && tick_q != LAST)
            tick_q <= tick_q + 1'b1;
    end

    assign expired = run && (tick_q == LAST);
endmodule

// File: rtl/sip_word_counter.sv
// Saturating count of accepted padding words.
// Assumes: 'clear' and 'inc' never coincide (clear happens only when idle).
module sip_word_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Clear on a new run; add one per handshake, saturating at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clear)
            count <= '0;
        else if (inc && count != '1)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/sync_pad_inserter.sv
// Issues all-ones padding words until early user mode is reported or a
// cycle budget expires. The ratio is parked at unity during a run and
// restored on success.
// Assumes: start is a single-cycle pulse; early_user is synchronous to clk.
module sync_pad_inserter #(
    parameter int DATA_W         = 32,
    parameter int RATIO_W        = 2,
    parameter int RATIO_ONE      = 0,
    parameter int RATIO_RST      = 0,
    parameter int GAP_CYCLES     = 4,
    parameter int TIMEOUT_CYCLES = 200,
    parameter int CNT_W          = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               early_user,
    input  logic               ratio_wr_en,
    input  logic [RATIO_W-1:0] ratio_wr_data,
    output logic [RATIO_W-1:0] ratio,
    output logic               word_valid,
    output logic [DATA_W-1:0]  word_data,
    input  logic               word_ready,
    output logic               done,
    output logic               timeout,
    output logic [CNT_W-1:0]   extra_count
);
    import sip_pkg::*;

    localparam logic [DATA_W-1:0] FILL_WORD = '1;

    sip_state_e state_q;
    logic       valid_q, done_q, tmo_q;
    logic       start_go, enter, restore, hs, busy;
    logic       gap_zero, budget_out;

    assign busy     = (state_q != SIP_IDLE);
    assign start_go = start && !busy;
    assign enter    = start_go && !early_user;
    assign hs       = valid_q && word_ready;
    assign restore  = (state_q == SIP_GAP) && gap_zero && early_user;

    sip_ratio_reg #(
        .RATIO_W  (RATIO_W),
        .RATIO_ONE(RATIO_ONE),
        .RATIO_RST(RATIO_RST)
    ) u_ratio (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (ratio_wr_en),
        .wr_data(ratio_wr_data),
        .busy   (busy),
        .enter  (enter),
        .restore(restore),
        .ratio  (ratio)
    );

    sip_gap_counter #(.GAP(GAP_CYCLES)) u_gap (
        .clk  (clk),
        .rst_n(rst_n),
        .load (hs),
        .zero (gap_zero)
    );

    sip_budget_timer #(.LIMIT(TIMEOUT_CYCLES)) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start_go),
        .run    (busy),
        .expired(budget_out)
    );

    sip_word_counter #(.CNT_W(CNT_W)) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(start_go),
        .inc  (hs),
        .count(extra_count)
    );

    // Run sequencer: offer a word, wait out the gap, then check status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SIP_IDLE;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            tmo_q   <= 1'b0;
        end else begin
            case (state_q)
                SIP_IDLE: begin
                    if (start) begin
                        done_q <= early_user;
                        tmo_q  <= 1'b0;
                        if (!early_user) begin
                            state_q <= SIP_SEND;
                            valid_q <= 1'b1;
                        end
                    end
                end
                SIP_SEND: begin
                    if (budget_out) begin
                        state_q <= SIP_IDLE;
                        valid_q <= 1'b0;
                        tmo_q   <= 1'b1;
                    end else if (hs) begin
                        state_q <= SIP_GAP;
                        valid_q <= 1'b0;
                    end
                end
                SIP_GAP: begin
                    if (gap_zero && early_user) begin
                        state_q <= SIP_IDLE;
                        done_q  <= 1'b1;
                    end else if (budget_out) begin
                        state_q <= SIP_IDLE;
                        tmo_q   <= 1'b1;
                    end else if (gap_zero) begin
                        state_q <= SIP_SEND;
                        valid_q <= 1'b1;
                    end
                end
                default: begin
                    state_q <= SIP_IDLE;
                    valid_q <= 1'b0;
                end
            endcase
        end
    end

    assign word_valid = valid_q;
    assign word_data  = valid_q ? FILL_WORD : '0;
    assign done       = done_q;
    assign timeout    = tmo_q;
endmodule

// File: rtl/sip_checker.sv
// Temporal checks on the inserter's ports, attached by bind.
// Assumes: the same parameter values as the instance it is bound to.
module sip_checker #(
    parameter int DATA_W    = 32,
    parameter int RATIO_W   = 2,
    parameter int RATIO_ONE = 0,
    parameter int CNT_W     = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               word_ready,
    input logic               word_valid,
    input logic [DATA_W-1:0]  word_data,
    input logic               done,
    input logic               timeout,
    input logic [RATIO_W-1:0] ratio,
    input logic [CNT_W-1:0]   extra_count
);
    assert_fill_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> word_data == {DATA_W{1'b1}});

    assert_hold_offer_R1: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && !word_ready |=> word_valid || timeout);

    assert_unity_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ratio == RATIO_W'(RATIO_ONE));

    assert_gap_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid && word_ready |=> !word_valid);

    assert_quiet_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !word_valid);

    assert_count_on_handshake_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !start && !(word_valid && word_ready) |=> $stable(extra_count));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && timeout));
endmodule

bind sync_pad_inserter sip_checker #(
    .DATA_W   (DATA_W),
    .RATIO_W  (RATIO_W),
    .RATIO_ONE(RATIO_ONE),
    .CNT_W    (CNT_W)
) u_sip_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .word_ready (word_ready),
    .word_valid (word_valid),
    .word_data  (word_data),
    .done       (done),
    .timeout    (timeout),
    .ratio      (ratio),
    .extra_count(extra_count)
);

// File: tb/test_sync_pad_inserter.sv
// Self-checking bench: random success runs plus directed corner cases.
module test_sync_pad_inserter;
    localparam int DW  = 32;
    localparam int RW  = 2;
    localparam int G   = 4;
    localparam int L   = 200;
    localparam int CW  = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          early_user = 1'b0;
    logic          ratio_wr_en = 1'b0;
    logic [RW-1:0] ratio_wr_data = '0;
    logic [RW-1:0] ratio;
    logic          word_valid;
    logic [DW-1:0] word_data;
    logic          word_ready = 1'b0;
    logic          done;
    logic          timeout;
    logic [CW-1:0] extra_count;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sync_pad_inserter #(
        .DATA_W(DW), .RATIO_W(RW), .RATIO_ONE(0), .RATIO_RST(0),
        .GAP_CYCLES(G), .TIMEOUT_CYCLES(L), .CNT_W(CW)
    ) i_sync_pad_inserter (
        .clk(clk), .rst_n(rst_n), .start(start), .early_user(early_user),
        .ratio_wr_en(ratio_wr_en), .ratio_wr_data(ratio_wr_data),
        .ratio(ratio), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .done(done), .timeout(timeout),
        .extra_count(extra_count)
    );

    // Words accepted with ready held high before the budget expires.
    function automatic int words_in_budget(int limit, int gap);
        return (limit - 1) / (gap + 1) + 1;
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_ratio(int r);
        @(negedge clk);
        ratio_wr_en   = 1'b1;
        ratio_wr_data = RW'(r);
        @(negedge clk);
        ratio_wr_en   = 1'b0;
        check(ratio == RW'(r), "R9 idle write", ratio, r);
    endtask

    // Start a run that must end in success after n accepted words.
    task automatic run_ok(int n, int r);
        int seen  = 0;
        int since = 100;
        int guard = 0;
        write_ratio(r);
        early_user = (n == 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(timeout == 1'b0, "R8 start clears timeout", timeout, 0);
        check(extra_count == 0, "R8 start clears count", extra_count, 0);
        if (n == 0) begin
            check(done == 1'b1, "R3 done next cycle", done, 1);
            check(word_valid == 1'b0, "R3 no word", word_valid, 0);
            check(ratio == RW'(r), "R3 ratio kept", ratio, r);
            @(negedge clk);
            check(done == 1'b1 && extra_count == 0, "R3 steady", extra_count, 0);
            return;
        end
        check(done == 1'b0, "R8 start clears done", done, 0);
        check(ratio == '0, "R2 unity ratio", ratio, 0);
        check(word_valid == 1'b1, "R2 first word", word_valid, 1);
        while (seen < n && guard < 1000) begin
            logic rdy;
            guard++;
            since++;
            if (word_valid) begin
                check(word_data == '1, "R1 fill word", word_data, 32'hFFFF_FFFF);
                if (since <= G)
                    check(1'b0, "R4 gap too short", since, G + 1);
            end
            rdy = (($urandom % 4) != 0);
            word_ready = rdy;
            if (word_valid && rdy) begin
                seen++;
                since = 0;
                if (seen == n) early_user = 1'b1;
            end
            @(negedge clk);
        end
        word_ready = 1'b0;
        for (int i = 0; i < G; i++) begin
            check(done == 1'b0, "R5 done not before gap end", done, 0);
            check(word_valid == 1'b0, "R4 low during gap", word_valid, 0);
            @(negedge clk);
        end
        check(done == 1'b1, "R5 done at gap end", done, 1);
        check(ratio == RW'(r), "R5 ratio restored", ratio, r);
        check(extra_count == CW'(n), "R6 word count", extra_count, n);
        check(word_valid == 1'b0, "R5 no further word", word_valid, 0);
        early_user = 1'b0;
    endtask

    // Run with early user never seen and ready held high.
    task automatic run_timeout();
        int hs = 0;
        int exp_words = words_in_budget(L, G);
        write_ratio(2);
        early_user = 1'b0;
        word_ready = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < L; i++) begin
            if (word_valid) begin
                hs++;
                check(ratio == '0, "R7 ratio unity while running", ratio, 0);
            end
            if (i == 50) begin
                ratio_wr_en   = 1'b1;
                ratio_wr_data = 2'd3;
            end else begin
                ratio_wr_en = 1'b0;
            end
            if (i == 52) check(ratio == '0, "R9 busy write ignored", ratio, 0);
            if (i == L - 1) check(timeout == 1'b0, "R7 no early timeout", timeout, 0);
            @(negedge clk);
        end
        word_ready = 1'b0;
        check(timeout == 1'b1, "R7 timeout on time", timeout, 1);
        check(word_valid == 1'b0, "R7 valid dropped", word_valid, 0);
        check(ratio == '0, "R7 ratio left at unity", ratio, 0);
        check(extra_count == CW'(exp_words), "R6 count at timeout", extra_count, exp_words);
        check(hs == exp_words, "R6 observed handshakes", hs, exp_words);
        repeat (10) @(negedge clk);
        check(timeout == 1'b1 && done == 1'b0, "R8 timeout sticky", timeout, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(word_valid == 1'b0, "R1 reset valid", word_valid, 0);
        check(done == 1'b0 && timeout == 1'b0, "R8 reset flags", done, 0);
        check(extra_count == 0, "R6 reset count", extra_count, 0);
        check(ratio == '0, "R9 reset ratio", ratio, 0);

        run_ok(0, 3);
        run_ok(1, 3);
        for (int k = 0; k < 8; k++)
            run_ok(int'($urandom % 6), int'(1 + $urandom % 3));
        run_timeout();
        run_ok(2, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule